// File: doc/BRIEF.md
# J1850 VPW Frame-State Monitor

This block sits on the receive side of a variable-pulse-width J1850 bus. It takes the raw bus level (1 = active) and brings it into the clock domain through a synchroniser. It then measures the length of each active and passive period in microseconds, using a one-cycle tick enable. From those lengths it reports where the bus is in its frame cycle. The states are: inside a frame, end of data, end of frame with separation running, idle, and break.

A transmitter uses the `tx_ok_o` output to learn when a new start of frame may be sent. A rising edge that arrives while the separation time is still running is taken as another node's start of frame. The period timer restarts from that edge.

A break is an active period of 240 µs or more. While receiving, a break discards the frame and sets a sticky invalid-symbol flag. If the node is receiving in 4X mode, it also requests an exit from 4X mode. While the node itself is transmitting, a break raises a transmit-abort pulse instead.

A completed frame sets a sticky end-of-frame flag. Both flags stay set until their clear pulse.

Top module: `vpw_frame_monitor`

## Requirements
- R1: After reset, `state_o` is IDLE, both flags are 0, `tx_ok_o` is 1, and no pulse output is high. State codes on `state_o` are: IDLE=0, FRAME=1, EOD=2, SEP=3, BREAK=4.
- R2: While the bus is passive after a falling edge, `state_o` is FRAME for fewer than 200 ticks and EOD from 200 through 279 ticks.
- R3: On the 280th passive tick, `state_o` becomes SEP and the end-of-frame flag is set, unless the frame was broken.
- R4: On the 300th passive tick, `state_o` becomes IDLE. `tx_ok_o` is 1 only in IDLE.
- R5: A rising edge seen in SEP or IDLE gives a one-cycle `sof_o` pulse and makes `state_o` FRAME. The period timer restarts from that edge, so IDLE comes only 300 ticks after the next falling edge.
- R6: A rising edge during EOD is a response inside the same frame. `state_o` returns to FRAME and there is no `sof_o` pulse.
- R7: An active period that reaches 240 ticks is a break: `state_o` becomes BREAK, and stays BREAK while the bus stays active. Below 240 ticks the state stays FRAME.
- R8: A break while `tx_active_i` is 0 sets the invalid-symbol flag and gives one `frame_drop_o` pulse. No end-of-frame flag follows for that frame.
- R9: A break while receiving with `mode_4x_i` at 1 also gives one `exit_4x_o` pulse.
- R10: A break while `tx_active_i` is 1 gives one `tx_abort_o` pulse. It gives no `frame_drop_o` pulse, no `exit_4x_o` pulse and no invalid-symbol flag.
- R11: Both flags stay set until their own clear pulse. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse every microsecond |
| bus_rx_i | input | 1 | Raw bus level, 1 = active |
| tx_active_i | input | 1 | Local transmitter is driving a frame |
| mode_4x_i | input | 1 | Receiver is in 4X mode |
| eof_clr_i | input | 1 | Clears the end-of-frame flag |
| inv_clr_i | input | 1 | Clears the invalid-symbol flag |
| state_o | output | 3 | Bus state code |
| tx_ok_o | output | 1 | A start of frame may be sent now |
| eof_flag_o | output | 1 | Sticky end-of-frame flag |
| inv_flag_o | output | 1 | Sticky invalid-symbol flag |
| sof_o | output | 1 | Pulse: new frame started by a rising edge |
| frame_drop_o | output | 1 | Pulse: received frame discarded by a break |
| exit_4x_o | output | 1 | Pulse: leave 4X mode |
| tx_abort_o | output | 1 | Pulse: break during own transmission |

## Verification
Passive gaps are stopped exactly one tick before and exactly on each threshold (200, 280 and 300). This separates off-by-one errors in every boundary.

Rising edges are placed in three windows: after idle, inside end of data, and inside the separation window. A response edge is told apart from a new start of frame, and the restarted timer shows whether resynchronisation happened.

Active periods of 239 and 240 ticks test the break threshold. Breaks are repeated while receiving, while receiving in 4X mode, and while transmitting. This shows that each break outcome is routed only to its own output.

// File: rtl/vpw_mon_pkg.sv
package vpw_mon_pkg;
   typedef enum logic [2:0] {
      VST_IDLE  = 3'd0,
      VST_FRAME = 3'd1,
      VST_EOD   = 3'd2,
      VST_SEP   = 3'd3,
      VST_BREAK = 3'd4
   } vpw_state_e;
endpackage

// File: rtl/vpw_sync.sv
module vpw_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("vpw_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[gi] <= 1'b0;
            else        chain_q[gi] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[gi] <= 1'b0;
            else        chain_q[gi] <= chain_q[gi-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/vpw_span_timer.sv
module vpw_span_timer #(
   parameter int CW   = 9,
   parameter int CMAX = 300
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lvl_i,
   input  logic          tick_i,
   output logic          lvl_o,
   output logic          rise_o,
   output logic          fall_o,
   output logic [CW-1:0] cnt_o
);
   if (CMAX >= (1 << CW)) begin : g_bad_width
      $error("vpw_span_timer: CW too narrow for CMAX");
   end

   localparam logic [CW-1:0] CNT_TOP = CW'(CMAX);

   logic          lvl_q;
   logic [CW-1:0] cnt_q;

   assign rise_o = lvl_i & ~lvl_q;
   assign fall_o = ~lvl_i & lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
         cnt_q <= CNT_TOP;
      end else begin
         lvl_q <= lvl_i;
         if (rise_o || fall_o)
            cnt_q <= '0;
         else if (tick_i && cnt_q != CNT_TOP)
            cnt_q <= cnt_q + 1'b1;
      end
   end

   assign lvl_o = lvl_q;
   assign cnt_o = cnt_q;
endmodule

// File: rtl/vpw_sticky_flag.sv
module vpw_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end
endmodule

// File: rtl/vpw_frame_monitor.sv
module vpw_frame_monitor
   import vpw_mon_pkg::*;
#(
   parameter int EOD_US      = 200,
   parameter int EOF_US      = 280,
   parameter int IFS_US      = 300,
   parameter int BRK_US      = 240,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       bus_rx_i,
   input  logic       tx_active_i,
   input  logic       mode_4x_i,
   input  logic       eof_clr_i,
   input  logic       inv_clr_i,
   output logic [2:0] state_o,
   output logic       tx_ok_o,
   output logic       eof_flag_o,
   output logic       inv_flag_o,
   output logic       sof_o,
   output logic       frame_drop_o,
   output logic       exit_4x_o,
   output logic       tx_abort_o
);
   if (!(EOD_US > 0 && EOD_US < EOF_US && EOF_US < IFS_US)) begin : g_bad_order
      $error("vpw_frame_monitor: thresholds must rise EOD < EOF < IFS");
   end
   if (BRK_US < 2) begin : g_bad_brk
      $error("vpw_frame_monitor: BRK_US too small");
   end

   localparam int CMAX = (IFS_US > BRK_US) ? IFS_US : BRK_US;
   localparam int CW   = $clog2(CMAX + 1);
   localparam logic [CW-1:0] T_EOD = CW'(EOD_US);
   localparam logic [CW-1:0] T_EOF = CW'(EOF_US);
   localparam logic [CW-1:0] T_IFS = CW'(IFS_US);
   localparam logic [CW-1:0] T_EOF_M1 = CW'(EOF_US - 1);
   localparam logic [CW-1:0] T_BRK_M1 = CW'(BRK_US - 1);

   logic          bus_s;
   logic          lvl;
   logic          rise;
   logic          fall;
   logic [CW-1:0] cnt;
   logic          brk_q;
   logic          step;
   logic          brk_evt;
   logic          eof_evt;
   logic          sof_evt;
   vpw_state_e    st;

   vpw_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (bus_rx_i),
      .q_o   (bus_s)
   );

   vpw_span_timer #(.CW(CW), .CMAX(CMAX)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (bus_s),
      .tick_i (tick_i),
      .lvl_o  (lvl),
      .rise_o (rise),
      .fall_o (fall),
      .cnt_o  (cnt)
   );

   assign step    = tick_i & ~rise & ~fall;
   assign brk_evt = lvl & step & (cnt == T_BRK_M1);
   assign eof_evt = ~lvl & step & (cnt == T_EOF_M1) & ~brk_q;
   assign sof_evt = rise & (cnt >= T_EOF);

   always_comb begin
      if (lvl)             st = brk_q ? VST_BREAK : VST_FRAME;
      else if (cnt < T_EOD) st = VST_FRAME;
      else if (cnt < T_EOF) st = VST_EOD;
      else if (cnt < T_IFS) st = VST_SEP;
      else                  st = VST_IDLE;
   end

   assign state_o = st;
   assign tx_ok_o = (st == VST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         brk_q        <= 1'b0;
         sof_o        <= 1'b0;
         frame_drop_o <= 1'b0;
         exit_4x_o    <= 1'b0;
         tx_abort_o   <= 1'b0;
      end else begin
         if (brk_evt)      brk_q <= 1'b1;
         else if (sof_evt) brk_q <= 1'b0;
         sof_o        <= sof_evt;
         frame_drop_o <= brk_evt & ~tx_active_i;
         exit_4x_o    <= brk_evt & ~tx_active_i & mode_4x_i;
         tx_abort_o   <= brk_evt & tx_active_i;
      end
   end

   vpw_sticky_flag u_eof_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (eof_evt),
      .clr_i  (eof_clr_i),
      .flag_o (eof_flag_o)
   );

   vpw_sticky_flag u_inv_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (brk_evt & ~tx_active_i),
      .clr_i  (inv_clr_i),
      .flag_o (inv_flag_o)
   );
endmodule

module vpw_frame_monitor_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] state_o,
   input logic       eof_flag_o,
   input logic       inv_flag_o,
   input logic       eof_clr_i,
   input logic       inv_clr_i,
   input logic       sof_o,
   input logic       frame_drop_o,
   input logic       exit_4x_o,
   input logic       tx_abort_o
);
   // R3
   eof_in_sep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eof_flag_o) |-> state_o == 3'd3);
   // R5
   sof_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sof_o |-> state_o == 3'd1);
   // R8
   drop_sets_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_drop_o |-> inv_flag_o);
   // R10
   abort_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_abort_o |-> !frame_drop_o && !exit_4x_o);
   // R9
   exit_with_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exit_4x_o |-> frame_drop_o);
   // R11
   eof_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(eof_flag_o) |-> $past(eof_clr_i));
   // R11
   inv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(inv_flag_o) |-> $past(inv_clr_i));
endmodule

bind vpw_frame_monitor vpw_frame_monitor_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .state_o      (state_o),
   .eof_flag_o   (eof_flag_o),
   .inv_flag_o   (inv_flag_o),
   .eof_clr_i    (eof_clr_i),
   .inv_clr_i    (inv_clr_i),
   .sof_o        (sof_o),
   .frame_drop_o (frame_drop_o),
   .exit_4x_o    (exit_4x_o),
   .tx_abort_o   (tx_abort_o)
);

// File: tb/vpw_frame_monitor_tb_top.sv
`timescale 1ns/1ps
module vpw_frame_monitor_tb_top;
   localparam logic [2:0] S_IDLE = 3'd0, S_FRAME = 3'd1, S_EOD = 3'd2,
                          S_SEP = 3'd3, S_BREAK = 3'd4;

   typedef struct {
      string      req;
      logic [2:0] st;
      bit         eof;
      bit         inv;
      bit         txok;
      int         sof;
      int         drp;
      int         ex;
      int         abt;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0, rx = 1'b0, tx_act = 1'b0, m4 = 1'b0;
   logic eof_clr = 1'b0, inv_clr = 1'b0;
   logic [2:0] state;
   logic tx_ok, eof_f, inv_f, sof, drop, ex4, abort;

   int checks = 0, failures = 0;
   int n_sof = 0, n_drp = 0, n_ex = 0, n_abt = 0;
   int e_sof = 0, e_drp = 0, e_ex = 0, e_abt = 0;
   bit done = 1'b0;
   exp_t sbq[$];

   always #5 clk = ~clk;

   vpw_frame_monitor dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_rx_i(rx),
      .tx_active_i(tx_act), .mode_4x_i(m4), .eof_clr_i(eof_clr),
      .inv_clr_i(inv_clr), .state_o(state), .tx_ok_o(tx_ok),
      .eof_flag_o(eof_f), .inv_flag_o(inv_f), .sof_o(sof),
      .frame_drop_o(drop), .exit_4x_o(ex4), .tx_abort_o(abort)
   );

   // monitor: count pulses, then pop and compare
   always @(negedge clk) begin
      if (rst_n) begin
         n_sof += int'(sof);
         n_drp += int'(drop);
         n_ex  += int'(ex4);
         n_abt += int'(abort);
      end
      if (sbq.size() > 0) begin
         exp_t e;
         e = sbq.pop_front();
         checks++;
         if (state !== e.st || eof_f !== e.eof || inv_f !== e.inv ||
             tx_ok !== e.txok || n_sof != e.sof || n_drp != e.drp ||
             n_ex != e.ex || n_abt != e.abt) begin
            failures++;
            $display("FAIL %s: act st=%0d eof=%0b inv=%0b ok=%0b sof=%0d drop=%0d exit=%0d abort=%0d exp st=%0d eof=%0b inv=%0b ok=%0b sof=%0d drop=%0d exit=%0d abort=%0d",
               e.req, state, eof_f, inv_f, tx_ok, n_sof, n_drp, n_ex, n_abt,
               e.st, e.eof, e.inv, e.txok, e.sof, e.drp, e.ex, e.abt);
         end
      end
   end

   task automatic expect_st(string req, logic [2:0] st, bit eof, bit inv);
      exp_t e;
      e.req = req; e.st = st; e.eof = eof; e.inv = inv;
      e.txok = (st == S_IDLE);
      e.sof = e_sof; e.drp = e_drp; e.ex = e_ex; e.abt = e_abt;
      sbq.push_back(e);
      @(posedge clk); #1;
   endtask

   task automatic bus(logic v);
      @(posedge clk); #1 rx = v;
      repeat (4) @(posedge clk);
      #1;
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1 tick = 1'b1;
         @(posedge clk); #1 tick = 1'b0;
      end
      @(posedge clk); #1;
   endtask

   task automatic pulse_eof_clr();
      @(posedge clk); #1 eof_clr = 1'b1;
      @(posedge clk); #1 eof_clr = 1'b0;
   endtask

   task automatic pulse_inv_clr();
      @(posedge clk); #1 inv_clr = 1'b1;
      @(posedge clk); #1 inv_clr = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      expect_st("R1 reset", S_IDLE, 0, 0);

      bus(1); e_sof = 1;
      expect_st("R5 sof from idle", S_FRAME, 0, 0);
      ticks(100); bus(0); ticks(199);
      expect_st("R2 199 passive", S_FRAME, 0, 0);
      ticks(1);
      expect_st("R2 200 passive", S_EOD, 0, 0);
      ticks(79);
      expect_st("R3 279 passive", S_EOD, 0, 0);
      ticks(1);
      expect_st("R3 280 passive", S_SEP, 1, 0);
      ticks(19);
      expect_st("R4 299 passive", S_SEP, 1, 0);
      ticks(1);
      expect_st("R4 300 passive", S_IDLE, 1, 0);
      expect_st("R11 eof held", S_IDLE, 1, 0);
      pulse_eof_clr();
      expect_st("R11 eof cleared", S_IDLE, 0, 0);

      bus(1); e_sof = 2;
      expect_st("R5 second sof", S_FRAME, 0, 0);
      ticks(50); bus(0); ticks(250);
      expect_st("R2 gap 250", S_EOD, 0, 0);
      bus(1);
      expect_st("R6 response edge", S_FRAME, 0, 0);
      ticks(30); bus(0); ticks(285);
      expect_st("R3 sep reached", S_SEP, 1, 0);
      bus(1); e_sof = 3;
      expect_st("R5 early edge in sep", S_FRAME, 1, 0);
      ticks(20); bus(0); ticks(299);
      expect_st("R5 timer restarted", S_SEP, 1, 0);
      ticks(1);
      expect_st("R4 idle after resync", S_IDLE, 1, 0);
      pulse_eof_clr();

      bus(1); e_sof = 4;
      ticks(239);
      expect_st("R7 239 active", S_FRAME, 0, 0);
      ticks(1); e_drp = 1;
      expect_st("R8 break rx", S_BREAK, 0, 1);
      bus(0); ticks(300);
      expect_st("R8 no eof after break", S_IDLE, 0, 1);
      pulse_inv_clr();
      expect_st("R11 inv cleared", S_IDLE, 0, 0);

      m4 = 1'b1;
      bus(1); e_sof = 5;
      ticks(240); e_drp = 2; e_ex = 1;
      expect_st("R9 break in 4x", S_BREAK, 0, 1);
      bus(0); ticks(300);
      pulse_inv_clr();

      tx_act = 1'b1;
      bus(1); e_sof = 6;
      ticks(240); e_abt = 1;
      expect_st("R10 break while tx", S_BREAK, 0, 0);
      bus(0); ticks(300);
      tx_act = 1'b0; m4 = 1'b0;
      expect_st("R10 idle after tx break", S_IDLE, 0, 0);

      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule